// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block joins several identical FIFO slices into one deeper FIFO. Each slice has a small memory of its own with a local write pointer and a local read pointer. Two tokens travel around a ring of slices: a write token and a read token. Only the slice that holds the write token accepts a pushed word. Only the slice that holds the read token presents its oldest word on the shared read-data bus. Every other slice drives zeros onto that bus, and the top ORs the buses together.

When the write holder stores a word in its highest location, it raises a one-cycle cascade pulse toward the next slice. The next slice takes the write token on the same clock edge that commits that write. The read token moves the same way when the read holder releases its highest location. The cascade outputs of the last slice feed the first slice, which closes the ring. Only slice 0 has its first-load input tied active, so slice 0 holds both tokens after reset.

The combined empty flag comes from the slice that holds the read token, and the combined full flag comes from the slice that holds the write token. Reads are show-ahead: the oldest word is visible on the read-data bus whenever the FIFO is not empty, and a read removes it at the clock edge. One clock serves both the write side and the read side.

Top module: `cascadeFifo`

## Requirements
- R1: The FIFO stores up to SLICES*SLICE_DEPTH words. `full` is high exactly when that many words are held, and the words come out in the order they were written, across every slice boundary and across the wrap from the last slice back to slice 0.
- R2: While reset is held and in the first cycle after it, slice 0 holds both tokens (`wrTokens` and `rdTokens` equal 1; bit i stands for slice i), `empty` is 1 and `full` is 0.
- R3: At all times exactly one bit of `wrTokens` is set and exactly one bit of `rdTokens` is set.
- R4: The write token moves from slice i to slice (i+1) mod SLICES on the edge that commits a write into location SLICE_DEPTH-1 of slice i. It moves at no other time.
- R5: The read token moves from slice i to slice (i+1) mod SLICES on the edge that commits a read from location SLICE_DEPTH-1 of slice i. It moves at no other time.
- R6: While `empty` is 0, `rdData` shows the oldest stored word. A read with `rdEn` high removes that word on the clock edge.
- R7: A write while `full` is high is ignored: the tokens, the flags and the stored words do not change. A read while `empty` is high is ignored in the same way.
- R8: When the FIFO is neither empty nor full, a read and a write on the same edge both take effect, and the word count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write side and the read side |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Push request |
| wrData | input | WIDTH | Word to push |
| rdEn | input | 1 | Pop request |
| rdData | output | WIDTH | Oldest word (show-ahead) |
| full | output | 1 | Full flag of the slice holding the write token |
| empty | output | 1 | Empty flag of the slice holding the read token |
| wrTokens | output | SLICES | One-hot: which slice holds the write token |
| rdTokens | output | SLICES | One-hot: which slice holds the read token |

## Verification
The bench builds the block with three slices of four words each and a 16-bit word. With these sizes the total capacity is twelve words, so a short run fills the FIFO completely and wraps both tokens around the ring several times. Three slices also make the ring-closing hand-off from slice 2 to slice 0 a different step from the ordinary hand-offs between slices 0, 1 and 2. The bench tries overflow with a burst that is longer than the capacity and tries underflow on an empty FIFO. It then runs a long stretch of simultaneous reads and writes, which pushes both tokens past the wrap point while data is still held in the slices.

// File: rtl/cascFifoPkg.sv
package cascFifoPkg;
  // strobes from a slice's control to its storage
  typedef struct packed {
    logic wrGo;   // commit a write at the write address this cycle
    logic rdOwn;  // this slice drives the shared read bus
  } sliceStrobes_t;
endpackage

// File: rtl/cascSliceCtrl.sv
module cascSliceCtrl #(
  parameter int SLICE_DEPTH = 4,
  localparam int AW = (SLICE_DEPTH > 1) ? $clog2(SLICE_DEPTH) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic firstLoad,
  input  logic wrCascIn,
  input  logic rdCascIn,
  input  logic wrEn,
  input  logic rdEn,
  output logic wrCascOut,
  output logic rdCascOut,
  output logic holdWr,
  output logic holdRd,
  output logic sliceFull,
  output logic sliceEmpty,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output cascFifoPkg::sliceStrobes_t strobes
);
  localparam logic [AW-1:0] LAST = AW'(SLICE_DEPTH - 1);
  localparam logic [AW:0] FULLCNT = (AW + 1)'(SLICE_DEPTH);

  logic [AW:0] count;
  logic wrGo, rdGo;

  assign sliceFull  = (count == FULLCNT);
  assign sliceEmpty = (count == '0);
  assign wrGo = holdWr && wrEn && !sliceFull;
  assign rdGo = holdRd && rdEn && !sliceEmpty;
  assign wrCascOut = wrGo && (wrAddr == LAST);
  assign rdCascOut = rdGo && (rdAddr == LAST);
  assign strobes.wrGo  = wrGo;
  assign strobes.rdOwn = holdRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWr <= firstLoad;
      holdRd <= firstLoad;
      wrAddr <= '0;
      rdAddr <= '0;
      count  <= '0;
    end else begin
      holdWr <= (holdWr && !wrCascOut) || wrCascIn;
      holdRd <= (holdRd && !rdCascOut) || rdCascIn;
      if (wrGo) wrAddr <= (wrAddr == LAST) ? '0 : wrAddr + 1'b1;
      if (rdGo) rdAddr <= (rdAddr == LAST) ? '0 : rdAddr + 1'b1;
      if (wrGo && !rdGo)      count <= count + 1'b1;
      else if (rdGo && !wrGo) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/cascSliceData.sv
module cascSliceData #(
  parameter int WIDTH = 16,
  parameter int SLICE_DEPTH = 4,
  localparam int AW = (SLICE_DEPTH > 1) ? $clog2(SLICE_DEPTH) : 1
) (
  input  logic clk,
  input  cascFifoPkg::sliceStrobes_t strobes,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [SLICE_DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrGo) mem[wrAddr] <= wrData;
  end

  assign rdData = strobes.rdOwn ? mem[rdAddr] : '0;
endmodule

// File: rtl/cascSlice.sv
module cascSlice #(
  parameter int WIDTH = 16,
  parameter int SLICE_DEPTH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic firstLoad,
  input  logic wrCascIn,
  input  logic rdCascIn,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic wrCascOut,
  output logic rdCascOut,
  output logic holdWr,
  output logic holdRd,
  output logic sliceFull,
  output logic sliceEmpty
);
  localparam int AW = (SLICE_DEPTH > 1) ? $clog2(SLICE_DEPTH) : 1;

  cascFifoPkg::sliceStrobes_t strobes;
  logic [AW-1:0] wrAddr, rdAddr;

  cascSliceCtrl #(.SLICE_DEPTH(SLICE_DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .firstLoad(firstLoad),
    .wrCascIn(wrCascIn), .rdCascIn(rdCascIn),
    .wrEn(wrEn), .rdEn(rdEn),
    .wrCascOut(wrCascOut), .rdCascOut(rdCascOut),
    .holdWr(holdWr), .holdRd(holdRd),
    .sliceFull(sliceFull), .sliceEmpty(sliceEmpty),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes)
  );

  cascSliceData #(.WIDTH(WIDTH), .SLICE_DEPTH(SLICE_DEPTH)) i_data (
    .clk(clk), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/cascadeFifo.sv
module cascadeFifo #(
  parameter int WIDTH = 16,
  parameter int SLICES = 3,
  parameter int SLICE_DEPTH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic full,
  output logic empty,
  output logic [SLICES-1:0] wrTokens,
  output logic [SLICES-1:0] rdTokens
);
  logic [SLICES-1:0] wrCasc, rdCasc, sFull, sEmpty;
  logic [WIDTH-1:0] sData [SLICES];

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i + SLICES - 1) % SLICES;
    cascSlice #(.WIDTH(WIDTH), .SLICE_DEPTH(SLICE_DEPTH)) i_slice (
      .clk(clk), .rstN(rstN),
      .firstLoad(i == 0),
      .wrCascIn(wrCasc[PREV]), .rdCascIn(rdCasc[PREV]),
      .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
      .rdData(sData[i]),
      .wrCascOut(wrCasc[i]), .rdCascOut(rdCasc[i]),
      .holdWr(wrTokens[i]), .holdRd(rdTokens[i]),
      .sliceFull(sFull[i]), .sliceEmpty(sEmpty[i])
    );
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < SLICES; i++) rdData |= sData[i];
  end

  assign full  = |(wrTokens & sFull);
  assign empty = |(rdTokens & sEmpty);
endmodule

// File: rtl/cascadeFifoChecker.sv
module cascadeFifoChecker #(
  parameter int SLICES = 3
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic rdEn,
  input logic full,
  input logic empty,
  input logic [SLICES-1:0] wrTokens,
  input logic [SLICES-1:0] rdTokens
);
  function automatic logic [SLICES-1:0] rotNext(input logic [SLICES-1:0] v);
    logic [SLICES-1:0] r;
    r = '0;
    for (int i = 0; i < SLICES; i++) r[(i + 1) % SLICES] = v[i];
    return r;
  endfunction

  assert_wr_token_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrTokens) == 1);
  assert_rd_token_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rdTokens) == 1);
  assert_reset_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (wrTokens == 1 && rdTokens == 1 && empty && !full));
  assert_wr_token_move_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrTokens != $past(wrTokens)) |->
      ($past(rstN) && $past(wrEn && !full) && wrTokens == rotNext($past(wrTokens))));
  assert_rd_token_move_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdTokens != $past(rdTokens)) |->
      ($past(rstN) && $past(rdEn && !empty) && rdTokens == rotNext($past(rdTokens))));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (full && !rdEn) |=> (full && $stable(wrTokens)));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !wrEn) |=> (empty && $stable(rdTokens)));
endmodule

bind cascadeFifo cascadeFifoChecker #(.SLICES(SLICES)) i_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .full(full), .empty(empty), .wrTokens(wrTokens), .rdTokens(rdTokens)
);

// File: tb/test_cascadeFifo.sv
module test_cascadeFifo;
  localparam int WIDTH = 16;
  localparam int SLICES = 3;
  localparam int SLICE_DEPTH = 4;
  localparam int CAP = SLICES * SLICE_DEPTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic full, empty;
  logic [SLICES-1:0] wrTokens, rdTokens;

  int checks = 0;
  int errors = 0;
  int wrTotal = 0;
  int rdTotal = 0;
  logic [WIDTH-1:0] scoreQ[$];
  logic [WIDTH-1:0] nextVal = 16'h1000;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  cascadeFifo #(.WIDTH(WIDTH), .SLICES(SLICES), .SLICE_DEPTH(SLICE_DEPTH)) i_cascadeFifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .full(full), .empty(empty),
    .wrTokens(wrTokens), .rdTokens(rdTokens)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares ports with the scoreboard at the falling edge
  task automatic monitor(input bit willRead);
    int cnt;
    logic [SLICES-1:0] expWr, expRd;
    cnt = scoreQ.size();
    expWr = SLICES'(1) << ((wrTotal / SLICE_DEPTH) % SLICES);
    expRd = SLICES'(1) << ((rdTotal / SLICE_DEPTH) % SLICES);
    check(full == (cnt == CAP), "R1 full flag", 32'(full), 32'(cnt == CAP));
    check(empty == (cnt == 0), "R7 empty flag", 32'(empty), 32'(cnt == 0));
    check(wrTokens == expWr, "R4 write token", 32'(wrTokens), 32'(expWr));
    check(rdTokens == expRd, "R5 read token", 32'(rdTokens), 32'(expRd));
    if (cnt > 0) check(rdData == scoreQ[0], "R6 oldest word", 32'(rdData), 32'(scoreQ[0]));
    if (willRead && cnt > 0) begin
      void'(scoreQ.pop_front());
      rdTotal++;
    end
  endtask

  // driver: one cycle with optional push and pop
  task automatic cycle(input bit we, input bit re);
    int cnt;
    @(negedge clk);
    cnt = scoreQ.size();
    monitor(re);
    wrEn = we;
    rdEn = re;
    wrData = nextVal;
    if (we && cnt < CAP) begin
      scoreQ.push_back(nextVal);
      wrTotal++;
    end
    nextVal = nextVal + 16'h0111;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 during reset
    check(wrTokens == 1 && rdTokens == 1, "R2 tokens in reset", 32'({wrTokens, rdTokens}), 32'h9);
    check(empty && !full, "R2 flags in reset", 32'({empty, full}), 32'h2);
    rstN = 1'b1;
    @(negedge clk);
    check(wrTokens == 1 && rdTokens == 1, "R2 tokens after reset", 32'({wrTokens, rdTokens}), 32'h9);
    // R7 reads on empty are ignored
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1);
    // R1 cross one boundary
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1);
    // R1 R7 fill past capacity, writes while full ignored
    for (int i = 0; i < CAP + 4; i++) cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    check(full == 1'b1, "R7 full after overflow burst", 32'(full), 32'h1);
    // drain fully across the wrap, then extra reads on empty
    for (int i = 0; i < CAP + 3; i++) cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b0);
    check(empty == 1'b1, "R7 empty after drain", 32'(empty), 32'h1);
    // R8 simultaneous traffic, several wraps
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0);
    for (int i = 0; i < 4 * CAP; i++) cycle(1'b1, 1'b1);
    check(scoreQ.size() == 6, "R8 level held during streaming", 32'(scoreQ.size()), 32'd6);
    // mixed pattern
    for (int i = 0; i < 60; i++) cycle(i % 3 != 0, i % 2 == 0);
    for (int i = 0; i < CAP + 2; i++) cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b0);
    check(rdTotal == wrTotal, "R1 all words returned", 32'(rdTotal), 32'(wrTotal));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule